// File: doc/BRIEF.md
# Alternating Two-Bank Line Hold Store

This block keeps one display line of colour samples while the line before it is shown. It has two banks of channel slots. At any moment one bank captures and the other drives the held outputs. Three colour words arrive together on every cycle. A strobe per channel, issued by the upstream sampling sequencer, decides which slots of the capturing bank take a new word on that cycle. A single bank-select input swaps the two roles, normally once per line during blanking. When the banks swap, the words just gathered appear on all outputs at once.

Channels are grouped in triplets. A direction input sets which colour lands in which position of each triplet, so that a panel scanned from either end receives the same colour order.

The bank select has timing rules. It must not change shortly before the start of a line's sampling, and it must not change shortly after a start pulse. Both windows are set by inputs counted in clocks. A violation of either rule raises a one-cycle error flag.

Top module: `line_hold_pingpong`

## Requirements
- R1: The registered select chooses the bank roles. With select 1, bank one captures and bank two drives `held_out`. With select 0, bank two captures and bank one drives `held_out`. The select is taken in at every clock edge.
- R2: With `dir_fwd` = 1, channel k (counted from 0) takes `col_a` when k mod 3 = 0, `col_b` when k mod 3 = 1 and `col_c` when k mod 3 = 2.
- R3: With `dir_fwd` = 0, the triplet order is mirrored from the far end. Channel NUM_CH-1 takes `col_a`, NUM_CH-2 takes `col_b` and NUM_CH-3 takes `col_c`, repeating down to channel 0.
- R4: A slot of the capturing bank is written only on a clock edge where its own strobe bit (bit k for channel k) is 1. Otherwise it keeps its value. The bank that drives the outputs is never written.
- R5: `held_out` changes only at the clock edge where the registered select changes. From that edge on, it shows the bank that has just finished capturing, including any write made at that same edge. Channel k occupies bits [k*DATA_W +: DATA_W].
- R6: If `line_start` is 1 on an edge where fewer than `setup_clks` edges have passed since the select last changed, `setup_err` is 1 for the following cycle. An edge on which the select itself changes counts as 0 edges.
- R7: If the select changes on an edge where fewer than `gap_clks` edges have passed since the last `line_start`, `gap_err` is 1 for the following cycle. A start pulse on that same edge counts as 0 edges.
- R8: Reset clears both banks to zero, selects bank one as the output bank and clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_a | input | DATA_W | First colour sample of the triplet |
| col_b | input | DATA_W | Second colour sample of the triplet |
| col_c | input | DATA_W | Third colour sample of the triplet |
| smp_strobe | input | NUM_CH | Per-channel capture strobe |
| bank_sel | input | 1 | Bank role select (1: bank one captures) |
| dir_fwd | input | 1 | Triplet colour order (1: forward, 0: mirrored) |
| line_start | input | 1 | Start pulse of a line's sampling |
| setup_clks | input | CNT_W | Minimum edges from a select change to a start pulse |
| gap_clks | input | CNT_W | Minimum edges from a start pulse to a select change |
| held_out | output | NUM_CH*DATA_W | Held words of the output bank |
| setup_err | output | 1 | Select-to-start setup violation flag |
| gap_err | output | 1 | Start-to-select gap violation flag |

## Verification
A full forward sweep of triplet strobes fills one bank, and the swap that follows shows whether the colours landed in forward order. A reversed sweep with the mirrored direction, which skips one triplet and writes on the swap edge itself, separates the mirrored mapping from the forward one. It also tells slots that keep old values apart from slots that were freshly written, and shows whether a write on the swap edge is carried into the outputs. Outputs are compared on every cycle of capture, to catch any leak of capture into the displayed bank. The select and start-pulse spacings are placed just inside, just outside and exactly on top of each window, which exercises each error flag separately and both together.

// File: rtl/lh_pkg.sv
package lh_pkg;
  typedef enum logic [1:0] {
    COL_A = 2'd0,
    COL_B = 2'd1,
    COL_C = 2'd2
  } col_pick_e;

  function automatic col_pick_e pick_fwd(input int ch);
    return col_pick_e'(ch % 3);
  endfunction

  function automatic col_pick_e pick_rev(input int ch, input int nch);
    return col_pick_e'((nch - 1 - ch) % 3);
  endfunction
endpackage

// File: rtl/lh_rst_sync.sv
module lh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/lh_route.sv
module lh_route
  import lh_pkg::*;
#(
  parameter int NUM_CH = 300,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]        col_a,
  input  logic [DATA_W-1:0]        col_b,
  input  logic [DATA_W-1:0]        col_c,
  input  logic                     dir_fwd,
  output logic [NUM_CH*DATA_W-1:0] wr_data
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam col_pick_e FWD_PICK = pick_fwd(ch);
    localparam col_pick_e REV_PICK = pick_rev(ch, NUM_CH);
    col_pick_e pick;

    always_comb begin
      pick = dir_fwd ? FWD_PICK : REV_PICK;
      unique case (pick)
        COL_A:   wr_data[ch*DATA_W +: DATA_W] = col_a;
        COL_B:   wr_data[ch*DATA_W +: DATA_W] = col_b;
        default: wr_data[ch*DATA_W +: DATA_W] = col_c;
      endcase
    end
  end
endmodule

// File: rtl/lh_bank.sv
module lh_bank #(
  parameter int NUM_CH = 300,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [NUM_CH-1:0]        strobe,
  input  logic [NUM_CH*DATA_W-1:0] wr_data,
  output logic [NUM_CH*DATA_W-1:0] slot_flat
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    logic              slot_en;
    logic [DATA_W-1:0] slot_q;
    logic [DATA_W-1:0] slot_nxt;

    always_comb begin
      slot_en  = cap_en & strobe[ch];
      slot_nxt = slot_en ? wr_data[ch*DATA_W +: DATA_W] : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_nxt;
    end

    assign slot_flat[ch*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/lh_timing.sv
module lh_timing #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_sel,
  input  logic             line_start,
  input  logic [CNT_W-1:0] setup_clks,
  input  logic [CNT_W-1:0] gap_clks,
  output logic             sel_q,
  output logic             setup_err,
  output logic             gap_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] chg_cnt, chg_cur, chg_nxt;
  logic [CNT_W-1:0] st_cnt, st_cur, st_nxt;
  logic             sel_edge;
  logic             se_nxt, ge_nxt;

  always_comb begin
    sel_edge = bank_sel ^ sel_q;
    chg_cur  = sel_edge ? '0 : chg_cnt;
    st_cur   = line_start ? '0 : st_cnt;
    se_nxt   = line_start & (chg_cur < setup_clks);
    ge_nxt   = sel_edge & (st_cur < gap_clks);
    if (sel_edge)                chg_nxt = CNT_ONE;
    else if (chg_cnt == CNT_MAX) chg_nxt = CNT_MAX;
    else                         chg_nxt = chg_cnt + CNT_ONE;
    if (line_start)              st_nxt = CNT_ONE;
    else if (st_cnt == CNT_MAX)  st_nxt = CNT_MAX;
    else                         st_nxt = st_cnt + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      chg_cnt   <= CNT_MAX;
      st_cnt    <= CNT_MAX;
      setup_err <= 1'b0;
      gap_err   <= 1'b0;
    end else begin
      sel_q     <= bank_sel;
      chg_cnt   <= chg_nxt;
      st_cnt    <= st_nxt;
      setup_err <= se_nxt;
      gap_err   <= ge_nxt;
    end
  end
endmodule

// File: rtl/line_hold_pingpong.sv
module line_hold_pingpong #(
  parameter int NUM_CH = 300,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        col_a,
  input  logic [DATA_W-1:0]        col_b,
  input  logic [DATA_W-1:0]        col_c,
  input  logic [NUM_CH-1:0]        smp_strobe,
  input  logic                     bank_sel,
  input  logic                     dir_fwd,
  input  logic                     line_start,
  input  logic [CNT_W-1:0]         setup_clks,
  input  logic [CNT_W-1:0]         gap_clks,
  output logic [NUM_CH*DATA_W-1:0] held_out,
  output logic                     setup_err,
  output logic                     gap_err
);
  localparam int FLAT_W  = NUM_CH * DATA_W;
  localparam int NUM_BNK = 2;

  logic              rst_ns;
  logic              sel_q;
  logic [FLAT_W-1:0] wr_data;
  logic [FLAT_W-1:0] bank_flat [NUM_BNK];
  logic [FLAT_W-1:0] cap_view;

  lh_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  lh_route #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_route (
    .col_a   (col_a),
    .col_b   (col_b),
    .col_c   (col_c),
    .dir_fwd (dir_fwd),
    .wr_data (wr_data)
  );

  lh_timing #(.CNT_W(CNT_W)) u_timing (
    .clk        (clk),
    .rst_n      (rst_ns),
    .bank_sel   (bank_sel),
    .line_start (line_start),
    .setup_clks (setup_clks),
    .gap_clks   (gap_clks),
    .sel_q      (sel_q),
    .setup_err  (setup_err),
    .gap_err    (gap_err)
  );

  // bank 0 captures while sel_q is 1, bank 1 captures while sel_q is 0
  for (genvar b = 0; b < NUM_BNK; b++) begin : g_bank
    logic cap_en;
    assign cap_en = (b == 0) ? sel_q : ~sel_q;

    lh_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_ns),
      .cap_en    (cap_en),
      .strobe    (smp_strobe),
      .wr_data   (wr_data),
      .slot_flat (bank_flat[b])
    );
  end

  always_comb begin
    held_out = sel_q ? bank_flat[1] : bank_flat[0];
    cap_view = sel_q ? bank_flat[0] : bank_flat[1];
  end
endmodule

// File: rtl/lh_checker.sv
module lh_checker #(
  parameter int NUM_CH = 300,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_ns,
  input logic                     sel_q,
  input logic                     line_start,
  input logic [NUM_CH-1:0]        smp_strobe,
  input logic [NUM_CH*DATA_W-1:0] held_out,
  input logic [NUM_CH*DATA_W-1:0] cap_view,
  input logic                     setup_err,
  input logic                     gap_err
);
  p_hold_steady_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (sel_q == $past(sel_q)) |-> (held_out == $past(held_out)));

  p_swap_shows_capture_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    ((sel_q != $past(sel_q)) && ($past(smp_strobe) == '0)) |-> (held_out == $past(cap_view)));

  p_no_strobe_keeps_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (smp_strobe == '0) |=> ((sel_q != $past(sel_q)) || (cap_view == $past(cap_view))));

  p_setup_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    setup_err |-> $past(line_start));

  p_gap_needs_swap_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    gap_err |-> (sel_q != $past(sel_q)));
endmodule

bind line_hold_pingpong lh_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .sel_q      (sel_q),
  .line_start (line_start),
  .smp_strobe (smp_strobe),
  .held_out   (held_out),
  .cap_view   (cap_view),
  .setup_err  (setup_err),
  .gap_err    (gap_err)
);

// File: tb/line_hold_pingpong_bench.sv
module line_hold_pingpong_bench;
  localparam int NCH   = 300;
  localparam int W     = 8;
  localparam int CW    = 8;
  localparam int FW    = NCH * W;
  localparam int SETUP = 6;
  localparam int GAP   = 4;
  localparam int CSAT  = 255;

  typedef struct packed {
    int unsigned cyc;
    int unsigned req;
    logic [FW-1:0] held;
    logic se;
    logic ge;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] col_a = '0, col_b = '0, col_c = '0;
  logic [NCH-1:0] smp_strobe = '0;
  logic bank_sel = 1'b0, dir_fwd = 1'b1, line_start = 1'b0;
  logic [CW-1:0] setup_clks = CW'(SETUP), gap_clks = CW'(GAP);
  logic [FW-1:0] held_out;
  logic setup_err, gap_err;

  line_hold_pingpong #(.NUM_CH(NCH), .DATA_W(W), .CNT_W(CW)) u_line_hold_pingpong (
    .clk(clk), .rst_n(rst_n), .col_a(col_a), .col_b(col_b), .col_c(col_c),
    .smp_strobe(smp_strobe), .bank_sel(bank_sel), .dir_fwd(dir_fwd),
    .line_start(line_start), .setup_clks(setup_clks), .gap_clks(gap_clks),
    .held_out(held_out), .setup_err(setup_err), .gap_err(gap_err)
  );

  always #2 clk = ~clk;

  int unsigned cyc_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  // bench model of the requirements
  logic [W-1:0] b1 [NCH];
  logic [W-1:0] b2 [NCH];
  logic m_sel = 1'b0;
  int m_chg = CSAT, m_st = CSAT;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc_cnt) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (held_out !== e.held || setup_err !== e.se || gap_err !== e.ge) begin
        fails++;
        $display("FAIL R%0d cyc=%0d actual held=%h se=%b ge=%b expected held=%h se=%b ge=%b",
                 e.req, cyc_cnt, held_out, setup_err, gap_err, e.held, e.se, e.ge);
      end
    end
  end

  function automatic logic [W-1:0] pick_col(int ch, logic fwd, logic [W-1:0] a, b, c);
    int k;
    k = fwd ? (ch % 3) : ((NCH - 1 - ch) % 3);  // R2 forward, R3 mirrored
    return (k == 0) ? a : (k == 1) ? b : c;
  endfunction

  task automatic step(input logic [NCH-1:0] stb, input logic sel, input logic fwd,
                      input logic st, input logic [W-1:0] a, b, c, input int unsigned req);
    exp_t e;
    logic edge_now;
    int chg_cur, st_cur;
    @(posedge clk);
    #1;
    smp_strobe = stb; bank_sel = sel; dir_fwd = fwd; line_start = st;
    col_a = a; col_b = b; col_c = c;
    edge_now = (sel != m_sel);
    chg_cur  = edge_now ? 0 : m_chg;
    st_cur   = st ? 0 : m_st;
    e.se = st && (chg_cur < SETUP);        // R6
    e.ge = edge_now && (st_cur < GAP);     // R7
    for (int ch = 0; ch < NCH; ch++) begin
      if (stb[ch]) begin                   // R4
        if (m_sel) b1[ch] = pick_col(ch, fwd, a, b, c);
        else       b2[ch] = pick_col(ch, fwd, a, b, c);
      end
    end
    m_chg = edge_now ? 1 : ((m_chg >= CSAT) ? CSAT : m_chg + 1);
    m_st  = st ? 1 : ((m_st >= CSAT) ? CSAT : m_st + 1);
    m_sel = sel;
    for (int ch = 0; ch < NCH; ch++)       // R1 / R5 output bank
      e.held[ch*W +: W] = m_sel ? b2[ch] : b1[ch];
    e.cyc = cyc_cnt + 1;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input logic sel, input int unsigned req);
    for (int i = 0; i < n; i++) step('0, sel, dir_fwd, 1'b0, '0, '0, '0, req);
  endtask

  function automatic logic [NCH-1:0] grp(int g);
    logic [NCH-1:0] m;
    m = '0;
    m[3*g +: 3] = 3'b111;
    return m;
  endfunction

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin b1[ch] = '0; b2[ch] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8: reset state, outputs zero and flags low
    idle(6, 1'b0, 8);
    // R2: forward sweep into bank two; R5: outputs stay zero meanwhile
    for (int g = 0; g < NCH / 3; g++)
      step(grp(g), 1'b0, 1'b1, (g == 0), W'(g), W'(8'h80 + g), W'(8'h40 + g), 5);
    idle(8, 1'b0, 5);
    // R1: swap, bank two now drives the outputs (forward order, R2)
    step('0, 1'b1, 1'b1, 1'b0, '0, '0, '0, 2);
    idle(8, 1'b1, 1);
    // R3: mirrored sweep into bank one, triplet 50 skipped (R4)
    for (int g = NCH / 3 - 1; g >= 0; g--)
      step((g == 50) ? '0 : grp(g), 1'b1, 1'b0, (g == NCH / 3 - 1),
           W'(8'hA0 + g), W'(8'h20 + g), W'(8'hE0 - g), 3);
    idle(8, 1'b1, 4);
    // R5: swap edge also writes triplet 0; must show at once
    step(grp(0), 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 8'h33, 5);
    idle(4, 1'b0, 3);
    // R4: strobes while nothing swaps leave outputs untouched
    step(grp(7), 1'b0, 1'b1, 1'b0, 8'h5A, 8'h5B, 8'h5C, 4);
    idle(10, 1'b0, 4);
    // R6: start 3 edges after a select change (inside window)
    step('0, 1'b1, 1'b1, 1'b0, '0, '0, '0, 6);
    idle(2, 1'b1, 6);
    step('0, 1'b1, 1'b1, 1'b1, '0, '0, '0, 6);
    idle(10, 1'b1, 6);
    // R6: start exactly SETUP edges after a change (no flag)
    step('0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 6);
    idle(SETUP - 1, 1'b0, 6);
    step('0, 1'b0, 1'b1, 1'b1, '0, '0, '0, 6);
    idle(10, 1'b0, 7);
    // R7: select change 2 edges after a start
    step('0, 1'b0, 1'b1, 1'b1, '0, '0, '0, 7);
    idle(1, 1'b0, 7);
    step('0, 1'b1, 1'b1, 1'b0, '0, '0, '0, 7);
    idle(10, 1'b1, 7);
    // R7: change exactly GAP edges after a start (no flag)
    step('0, 1'b1, 1'b1, 1'b1, '0, '0, '0, 7);
    idle(GAP - 1, 1'b1, 7);
    step('0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 7);
    idle(10, 1'b0, 7);
    // R6 and R7 together: change and start on the same edge
    step('0, 1'b1, 1'b1, 1'b1, '0, '0, '0, 6);
    idle(4, 1'b1, 7);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule